// File: doc/BRIEF.md
# Event Edge Timestamp Capture Unit

This block timestamps the rising edges of an external, asynchronous event signal, such as a once-per-second timing pulse. The timestamps are in units of four clock periods. Two counters of equal width advance on a shared clock-enable that fires once every four clocks. The first counter, the timebase, never stops. The second counter measures the time since the last edge: every rising edge of the synchronised event level restarts it from zero.

Software-style polling reads the result. On each poll strobe the block samples the event level and compares it with the level it recorded at the previous enabled poll. A low-to-high change produces a capture. The stored timestamp is then the timebase minus the elapsed count, truncated to the counter width. That difference is the timebase value at the moment of the edge, so the delay between the edge and the poll adds no jitter to the result. A high-to-low change produces no capture; it only returns the echo pin to its inactive level. The echo pin is a visual indicator whose polarity can be chosen.

Top module: `evt_stamp_unit`

## Requirements
- R1: The timebase counter is CNT_W bits wide (16 by default) and wraps modulo 2^CNT_W. Two captures whose edges are N timebase steps apart differ by N mod 2^CNT_W.
- R2: Both counters advance by one on every fourth clock and hold their value on the other clocks. Two rising edges spaced 4·K clocks apart give timestamps that differ by K mod 2^CNT_W.
- R3: A rising edge of the synchronised event level restarts the elapsed counter from zero. The captured timestamp is the timebase minus the elapsed count, modulo 2^CNT_W, so it does not depend on how many clocks pass between the edge and the poll.
- R4: The event input passes through a two-flop synchroniser and then a level register. The elapsed counter restarts on the same clock edge at which the level register goes high. For an input that rises between two clock edges, a poll sampled on the third rising clock edge after the change sees the old level. A poll sampled on the fourth edge sees the new level.
- R5: A poll (poll_i high at a rising clock edge, with evt_en_i high) captures only if the sampled level is high and the level recorded at the previous enabled poll was low. stamp_valid_o is then high for exactly the one cycle after that edge, and stamp_o takes the new timestamp on the same edge. A further poll while the level stays high produces no capture.
- R6: A poll that sees a high-to-low change produces no capture, leaves stamp_o unchanged and drives the echo to its inactive level.
- R7: A capture sets the echo to its active level. echo_o is 1 when the echo is active and echo_invert_i is 0. echo_invert_i = 1 inverts the pin, so the active level is then 0.
- R8: While evt_en_i is 0, polls are ignored. There is no capture, and stamp_o, the echo and the recorded level all keep their values.
- R9: After a synchronous active-low reset, stamp_o is 0, stamp_valid_o is 0, the echo is inactive and the recorded level is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_in | input | 1 | Asynchronous event signal |
| evt_en_i | input | 1 | Event input assigned; 0 makes polls no-ops |
| poll_i | input | 1 | Poll strobe, one cycle per poll |
| echo_invert_i | input | 1 | 1 selects inverted echo polarity |
| stamp_o | output | CNT_W | Last captured timestamp |
| stamp_valid_o | output | 1 | One-cycle pulse marking a new capture |
| echo_o | output | 1 | Echo indicator pin |

## Verification
The bench builds the unit with CNT_W = 8, leaving the prescale and synchroniser depth at their defaults. With 8-bit counters the timebase wraps after 1024 clocks, so captures spaced across one or two full wraps (which must give equal timestamps) and a gap of 1100 clocks (which must give a residue of 19) fit within a short run. The narrow counters also keep the elapsed count well short of wrapping for every poll delay the bench uses. Each pair of edges is placed an exact number of clocks apart and polled after a different delay. The earliest-capture boundary is probed with a poll on the third edge and a poll on the fourth.

// File: rtl/evt_stamp_pkg.sv
// Package: shared types for the event timestamp unit.
// Assumes: nothing beyond SystemVerilog 2017.
package evt_stamp_pkg;

    // Decision taken by an enabled poll
    typedef enum logic [1:0] {
        POLL_IDLE    = 2'd0,
        POLL_CAPTURE = 2'd1,
        POLL_RELEASE = 2'd2
    } poll_act_e;

    // Classify a poll from the current and the previously recorded level
    function automatic poll_act_e classify_poll(input logic lvl_now, input logic lvl_prev);
        if (lvl_now && !lvl_prev)
            return POLL_CAPTURE;
        else if (!lvl_now && lvl_prev)
            return POLL_RELEASE;
        else
            return POLL_IDLE;
    endfunction

endpackage

// File: rtl/evt_level_sync.sv
// Module: evt_level_sync
// Brings the asynchronous event input into the clock domain through a
// STAGES-deep flop chain, then registers the level once more. The rise
// pulse is high in the cycle before the level register goes high, so a
// counter cleared on it reads zero in the first cycle the level reads high.
// Assumes: STAGES >= 2, synchronous active-low reset.
module evt_level_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain_q;
    logic         level_q;

    // Synchroniser chain, one flop per stage
    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage captures the raw input
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_i;
                end
            end else begin : g_next
                // Later stages follow their predecessor
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    // Level register: the level seen by polls
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= chain_q[TOP];
    end

    // Rise detect on the synchronised signal
    always_comb rise_o = chain_q[TOP] & ~level_q;

    assign level_o = level_q;

    // R4: a rise is followed by a high level on the next cycle
    a_r4_rise_sets_level: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> level_o);

endmodule

// File: rtl/stamp_prescaler.sv
// Module: stamp_prescaler
// Free-running DIV_W-bit counter. It emits a one-cycle tick each time it
// reaches its all-ones value, i.e. once every 2^DIV_W clocks.
// Assumes: DIV_W >= 1, synchronous active-low reset.
module stamp_prescaler #(
    parameter int DIV_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam logic [DIV_W-1:0] LAST = '1;

    logic [DIV_W-1:0] div_q;

    // Divider count, wraps naturally
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    // Tick on the terminal count
    always_comb tick_o = (div_q == LAST);

    // R2: ticks are never back to back
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/stamp_counters.sv
// Module: stamp_counters
// Two CNT_W-bit counters stepped by a shared tick: a free-running timebase
// and an elapsed counter that a restart pulse forces to zero. The restart
// takes priority over a tick in the same cycle.
// Assumes: the restart comes from synchronised logic; synchronous active-low reset.
module stamp_counters #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             restart_i,
    output logic [CNT_W-1:0] base_o,
    output logic [CNT_W-1:0] since_o
);
    logic [CNT_W-1:0] base_q;
    logic [CNT_W-1:0] since_q;

    // Timebase: advance on each tick, wrapping modulo 2^CNT_W
    always_ff @(posedge clk) begin
        if (!rst_n)      base_q <= '0;
        else if (tick_i) base_q <= base_q + 1'b1;
    end

    // Elapsed count: restart on an edge, otherwise advance on each tick
    always_ff @(posedge clk) begin
        if (!rst_n)         since_q <= '0;
        else if (restart_i) since_q <= '0;
        else if (tick_i)    since_q <= since_q + 1'b1;
    end

    assign base_o  = base_q;
    assign since_o = since_q;

    // R1: a tick steps the timebase by exactly one, wrapping
    a_r1_base_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> base_o == CNT_W'($past(base_o) + 1));

    // R2: without a tick the timebase holds
    a_r2_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(base_o));

    // R3: a restart leaves the elapsed count at zero
    a_r3_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> since_o == '0);

endmodule

// File: rtl/evt_poll_ctrl.sv
// Module: evt_poll_ctrl
// Poll logic. On each enabled poll it compares the current event level
// with the level recorded at the previous enabled poll. On a low-to-high
// change it stores timebase minus elapsed count and pulses valid for one
// cycle. It also tracks the echo state.
// Assumes: the level and the counters are consistent in every cycle;
// synchronous active-low reset.
module evt_poll_ctrl
    import evt_stamp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             poll_i,
    input  logic             enable_i,
    input  logic             level_i,
    input  logic [CNT_W-1:0] base_i,
    input  logic [CNT_W-1:0] since_i,
    input  logic             invert_i,
    output logic [CNT_W-1:0] stamp_o,
    output logic             valid_o,
    output logic             echo_o
);
    logic             prev_q;
    logic [CNT_W-1:0] stamp_q;
    logic             valid_q;
    logic             echo_act_q;
    logic             poll_live;
    poll_act_e        act;

    // Decide what this cycle's poll does
    always_comb begin
        poll_live = poll_i & enable_i;
        act       = poll_live ? classify_poll(level_i, prev_q) : POLL_IDLE;
    end

    // Recorded level, updated only by enabled polls
    always_ff @(posedge clk) begin
        if (!rst_n)         prev_q <= 1'b0;
        else if (poll_live) prev_q <= level_i;
    end

    // Timestamp register and one-cycle valid pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stamp_q <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= (act == POLL_CAPTURE);
            if (act == POLL_CAPTURE)
                stamp_q <= base_i - since_i;
        end
    end

    // Echo state: set on capture, cleared on release
    always_ff @(posedge clk) begin
        if (!rst_n)                    echo_act_q <= 1'b0;
        else if (act == POLL_CAPTURE)  echo_act_q <= 1'b1;
        else if (act == POLL_RELEASE)  echo_act_q <= 1'b0;
    end

    // Pin polarity
    always_comb echo_o = echo_act_q ^ invert_i;

    assign stamp_o = stamp_q;
    assign valid_o = valid_q;

    // R5: a valid pulse only follows an enabled poll of a high level
    a_r5_valid_cause: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(poll_i && enable_i && level_i));

    // R5: two captures never come back to back
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R8: a poll while disabled changes nothing
    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_i && !enable_i) |=> (!valid_o && $stable(stamp_o) && $stable(echo_act_q)));

    // R6: a poll seeing a low level leaves the echo inactive and no capture
    a_r6_low_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_i && enable_i && !level_i) |=> (!echo_act_q && !valid_o));

endmodule

// File: rtl/evt_stamp_unit.sv
// Module: evt_stamp_unit (top)
// Event timestamp capture: synchroniser, prescaler, counter pair and poll
// logic. The timestamp is the timebase minus the elapsed count since the
// last rising edge, in units of 2^DIV_W clocks.
// Assumes: poll_i is synchronous to clk; evt_in may be fully asynchronous.
module evt_stamp_unit #(
    parameter int CNT_W       = 16,
    parameter int DIV_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_in,
    input  logic             evt_en_i,
    input  logic             poll_i,
    input  logic             echo_invert_i,
    output logic [CNT_W-1:0] stamp_o,
    output logic             stamp_valid_o,
    output logic             echo_o
);
    logic             level;
    logic             rise;
    logic             tick;
    logic [CNT_W-1:0] base_cnt;
    logic [CNT_W-1:0] since_cnt;

    evt_level_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (evt_in),
        .level_o (level),
        .rise_o  (rise)
    );

    stamp_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    stamp_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .restart_i (rise),
        .base_o    (base_cnt),
        .since_o   (since_cnt)
    );

    evt_poll_ctrl #(.CNT_W(CNT_W)) u_poll (
        .clk      (clk),
        .rst_n    (rst_n),
        .poll_i   (poll_i),
        .enable_i (evt_en_i),
        .level_i  (level),
        .base_i   (base_cnt),
        .since_i  (since_cnt),
        .invert_i (echo_invert_i),
        .stamp_o  (stamp_o),
        .valid_o  (stamp_valid_o),
        .echo_o   (echo_o)
    );

    // R3: a high level seen by the poll logic implies an elapsed count already restarted
    a_r3_level_consistent: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(level) |-> since_cnt == '0);

endmodule

// File: tb/evt_stamp_unit_bench.sv
`timescale 1ns/1ps
module evt_stamp_unit_bench;
    localparam int CNT_W = 8;
    localparam int MODV  = 1 << CNT_W;
    localparam int NV    = 6;

    // Vector table: rise-to-rise gap (clocks), poll delay (negedges), early-poll probe
    localparam int GAP  [NV] = '{0, 400, 1024, 1100, 200, 2048};
    localparam int PDLY [NV] = '{5, 3, 4, 12, 7, 20};
    localparam int EARLY[NV] = '{0, 0, 1, 0, 1, 0};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             evt_in = 1'b0;
    logic             evt_en_i = 1'b1;
    logic             poll_i = 1'b0;
    logic             echo_invert_i = 1'b0;
    logic [CNT_W-1:0] stamp_o;
    logic             stamp_valid_o;
    logic             echo_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  cyc     = 0;
    bit  done    = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    evt_stamp_unit #(.CNT_W(CNT_W)) u_evt_stamp_unit (
        .clk           (clk),
        .rst_n         (rst_n),
        .evt_in        (evt_in),
        .evt_en_i      (evt_en_i),
        .poll_i        (poll_i),
        .echo_invert_i (echo_invert_i),
        .stamp_o       (stamp_o),
        .stamp_valid_o (stamp_valid_o),
        .echo_o        (echo_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One-cycle poll; on return the registered result is visible
    task automatic do_poll();
        poll_i = 1'b1;
        @(negedge clk);
        poll_i = 1'b0;
    endtask

    initial begin
        int rise_cyc;
        int prev_stamp;
        int held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        check("R9 stamp after reset", int'(stamp_o), 0);
        check("R9 valid after reset", int'(stamp_valid_o), 0);
        check("R9 echo inactive after reset", int'(echo_o), 0);

        rise_cyc   = cyc + 10;
        prev_stamp = 0;
        for (int v = 0; v < NV; v++) begin
            int target;
            target = (v == 0) ? rise_cyc : rise_cyc + GAP[v];
            while (cyc < target) @(negedge clk);
            rise_cyc = cyc;
            evt_in = 1'b1;
            if (EARLY[v] != 0) begin
                // R4: poll sampled on the third edge sees the old level
                repeat (2) @(negedge clk);
                do_poll();
                check("R4 no capture on third edge", int'(stamp_valid_o), 0);
            end else begin
                repeat (PDLY[v]) @(negedge clk);
            end
            // R4/R5: capture on this poll
            do_poll();
            check("R5 capture valid", int'(stamp_valid_o), 1);
            check("R7 echo active after capture", int'(echo_o), 1);
            if (v > 0)
                // R1/R2/R3: timestamp spacing follows edge spacing
                check("R3 stamp spacing", (int'(stamp_o) - prev_stamp + MODV) % MODV,
                      (GAP[v] / 4) % MODV);
            prev_stamp = int'(stamp_o);
            @(negedge clk);
            check("R5 valid is one cycle", int'(stamp_valid_o), 0);
            // R5: polling again while high gives nothing
            do_poll();
            check("R5 no repeat capture", int'(stamp_valid_o), 0);
            // R6: falling level releases echo, no capture
            evt_in = 1'b0;
            repeat (5) @(negedge clk);
            do_poll();
            check("R6 no capture on fall", int'(stamp_valid_o), 0);
            check("R6 echo inactive on fall", int'(echo_o), 0);
            check("R6 stamp held on fall", int'(stamp_o), prev_stamp);
        end

        // R8: disabled input ignores polls
        evt_en_i = 1'b0;
        evt_in = 1'b1;
        repeat (6) @(negedge clk);
        do_poll();
        check("R8 no capture when disabled", int'(stamp_valid_o), 0);
        check("R8 stamp held when disabled", int'(stamp_o), prev_stamp);
        check("R8 echo held when disabled", int'(echo_o), 0);
        held = cyc;
        // Re-enable: recorded level stayed low so the next poll captures
        evt_en_i = 1'b1;
        do_poll();
        check("R8 recorded level untouched", int'(stamp_valid_o), 1);
        if (held < 0) n_fail++;

        // R7: inverted echo polarity
        echo_invert_i = 1'b1;
        #1;
        check("R7 inverted echo active", int'(echo_o), 0);
        evt_in = 1'b0;
        repeat (5) @(negedge clk);
        do_poll();
        check("R7 inverted echo inactive", int'(echo_o), 1);

        // R9: reset mid-run clears the stamp
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R9 stamp cleared by reset", int'(stamp_o), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule